// File: doc/BRIEF.md
# Indexed Host Register Port with Interrupt

This block is the host-side register file of a small Ethernet controller. The host sees only two locations: an index port and a data port. A write to the index port selects one of up to 256 internal byte registers. Later reads and writes on the data port act on the selected register until the index changes. The register file holds network control and status, transmit control, receive control, wake control, the interrupt status and mask pair, and the PHY access control, address and data registers. It drives a level-sensitive interrupt line.

The packet buffer, frame filtering and the MAC datapath are not part of this block. Toward the MAC it gives a one-cycle transmit-start strobe and accepts a one-cycle transmit-done pulse. The status bits follow mixed rules: some clear when read, some clear when written with 1, and some are read-only. A soft reset, started through the control register, keeps a few bits. An active-low hard reset input clears those bits as well.

Top module: `nic_host_regs`

## Requirements
- R1: A write with `busIsData`=0 latches `busWdata` as the register index. A read with `busIsData`=0 returns the latched index. The index is 0x00 after hard reset.
- R2: `irqOut` is high exactly when some bit of the low 4 bits of (interrupt status at 0xFE AND interrupt mask at 0xFF) is set. Mask bits 7..4 never raise it.
- R3: A data write to index 0xFE clears each interrupt status bit in [3:0] that is written as 1 and leaves the others. Bits 7..4 of 0xFE always read 0.
- R4: A data read of the network status register (index 0x01) returns its current value and then clears its transmit-complete bits 3 and 2.
- R5: A data write to index 0x01 clears only those of bits 5, 3 and 2 that are written as 1. Bits 7, 6, 4, 1 and 0 are not changed by writes.
- R6: A data write to the control register (index 0x00) stores the written byte with bit 3 (full duplex) forced to 1.
- R7: A control write with bit 0 set performs a soft reset. Control becomes (written bits 7..6) | 0x08. Status keeps bit 5 and gets bit 6 (link up) set, with all other bits cleared. Mask, interrupt status, transmit control (0x02), receive control (0x05) and PHY control (0x0B) clear, the PHY address (0x0C) returns to 0x40, and the packet index returns to 0. Wake control (0x0F) is unchanged.
- R8: A data write to index 0x02 with bit 0 set stores the byte and pulses `txStart` for exactly the following cycle. Bit 0 stays set until a `txDone` pulse. That pulse clears it, sets status bit 2 when the one-bit packet index is 0 or bit 3 when it is 1, sets interrupt status bit 1, and toggles the packet index.
- R9: Indices 0x28, 0x29, 0x2A and 0x2B read as 0x46, 0x0A, 0x00 and 0x90 with default parameters. Indices 0x03 and 0x04 read as 0x00.
- R10: Indices with no register read as 0x00, and writes to them change no state.
- R11: After hard reset (`rstN` low) control reads 0x08, status 0x40, wake control 0x00, PHY address 0x40, and every other register 0x00.
- R12: Receive control (0x05), PHY control (0x0B), PHY address (0x0C), PHY data low/high (0x0D/0x0E) and wake control (0x0F) read back the last byte written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low hard reset |
| busSel | input | 1 | Host access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busIsData | input | 1 | 0 = index port, 1 = data port |
| busWdata | input | 8 | Host write data |
| busRdata | output | 8 | Host read data, valid in the access cycle |
| txDone | input | 1 | One-cycle pulse from the MAC: frame sent |
| txStart | output | 1 | One-cycle strobe to the MAC: send the staged frame |
| irqOut | output | 1 | Level interrupt request |

## Verification
The properties assume that the MAC pulses `txDone` only while a transmit is pending, and never in the same cycle as a host access that touches the status, interrupt or transmit-control registers. They also assume that host accesses are single-cycle strobes with stable data during the access. The directed bench keeps to this: it drives every bus access and every `txDone` pulse from its own tasks, one event per cycle, at the falling edge. It sends `txDone` only after it has seen `txStart` and has read transmit control back as pending.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;
  localparam int REG_W   = 8;
  localparam int IDX_W   = 8;
  localparam int IRQ_SRC = 4;

  localparam logic [IDX_W-1:0] IDX_CTRL    = 8'h00;
  localparam logic [IDX_W-1:0] IDX_STAT    = 8'h01;
  localparam logic [IDX_W-1:0] IDX_TXCTL   = 8'h02;
  localparam logic [IDX_W-1:0] IDX_TXST1   = 8'h03;
  localparam logic [IDX_W-1:0] IDX_TXST2   = 8'h04;
  localparam logic [IDX_W-1:0] IDX_RXCTL   = 8'h05;
  localparam logic [IDX_W-1:0] IDX_PHYCTL  = 8'h0B;
  localparam logic [IDX_W-1:0] IDX_PHYADR  = 8'h0C;
  localparam logic [IDX_W-1:0] IDX_PHYDLO  = 8'h0D;
  localparam logic [IDX_W-1:0] IDX_PHYDHI  = 8'h0E;
  localparam logic [IDX_W-1:0] IDX_WAKE    = 8'h0F;
  localparam logic [IDX_W-1:0] IDX_VIDL    = 8'h28;
  localparam logic [IDX_W-1:0] IDX_VIDH    = 8'h29;
  localparam logic [IDX_W-1:0] IDX_PIDL    = 8'h2A;
  localparam logic [IDX_W-1:0] IDX_PIDH    = 8'h2B;
  localparam logic [IDX_W-1:0] IDX_ISR     = 8'hFE;
  localparam logic [IDX_W-1:0] IDX_IMR     = 8'hFF;

  localparam logic [REG_W-1:0] CTRL_FDX    = 8'h08;
  localparam logic [REG_W-1:0] CTRL_KEEP   = 8'hC0;
  localparam logic [REG_W-1:0] STAT_LINK   = 8'h40;
  localparam logic [REG_W-1:0] STAT_KEEP   = 8'h20;
  localparam logic [REG_W-1:0] STAT_TXDONE = 8'h0C;
  localparam logic [REG_W-1:0] STAT_W1C    = 8'h2C;
  localparam int               ISR_TXBIT   = 1;

  // Strobes handed from the control side to the register datapath
  typedef struct packed {
    logic             wrStb;
    logic             rdStb;
    logic             softRst;
    logic [IDX_W-1:0] idx;
    logic [REG_W-1:0] wdata;
  } regCmd_t;
endpackage

// File: rtl/nic_regs_ctl.sv
module nic_regs_ctl
  import nic_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic             busIsData,
  input  logic [REG_W-1:0] busWdata,
  output regCmd_t          cmd,
  output logic [IDX_W-1:0] curIdx,
  output logic             txStart
);
  logic idxWr;
  logic dataWr;
  logic dataRd;
  logic txKick;

  assign idxWr  = busSel &&  busWr && !busIsData;
  assign dataWr = busSel &&  busWr &&  busIsData;
  assign dataRd = busSel && !busWr &&  busIsData;
  assign txKick = dataWr && (curIdx == IDX_TXCTL) && busWdata[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx  <= '0;
      txStart <= 1'b0;
    end else begin
      if (idxWr) curIdx <= busWdata[IDX_W-1:0];
      txStart <= txKick;
    end
  end

  always_comb begin
    cmd.wrStb   = dataWr;
    cmd.rdStb   = dataRd;
    cmd.softRst = dataWr && (curIdx == IDX_CTRL) && busWdata[0];
    cmd.idx     = curIdx;
    cmd.wdata   = busWdata;
  end
endmodule

// File: rtl/nic_regs_dp.sv
module nic_regs_dp
  import nic_regs_pkg::*;
#(
  parameter logic [15:0]      VENDOR_ID    = 16'h0A46,
  parameter logic [15:0]      PRODUCT_ID   = 16'h9000,
  parameter logic [REG_W-1:0] PHY_ADDR_RST = 8'h40
) (
  input  logic             clk,
  input  logic             rstN,
  input  regCmd_t          cmd,
  input  logic             txDone,
  output logic [REG_W-1:0] rdData,
  output logic             irqOut
);
  logic [REG_W-1:0]   ctrlQ,   ctrlD;
  logic [REG_W-1:0]   statQ,   statD;
  logic [REG_W-1:0]   txCtlQ,  txCtlD;
  logic [REG_W-1:0]   rxCtlQ,  rxCtlD;
  logic [REG_W-1:0]   wakeQ,   wakeD;
  logic [REG_W-1:0]   imrQ,    imrD;
  logic [IRQ_SRC-1:0] isrQ,    isrD;
  logic [REG_W-1:0]   phyCtlQ, phyCtlD;
  logic [REG_W-1:0]   phyAdrQ, phyAdrD;
  logic [2*REG_W-1:0] phyDatQ, phyDatD;
  logic               pktIdxQ, pktIdxD;

  always_comb begin
    ctrlD   = ctrlQ;
    statD   = statQ;
    txCtlD  = txCtlQ;
    rxCtlD  = rxCtlQ;
    wakeD   = wakeQ;
    imrD    = imrQ;
    isrD    = isrQ;
    phyCtlD = phyCtlQ;
    phyAdrD = phyAdrQ;
    phyDatD = phyDatQ;
    pktIdxD = pktIdxQ;

    if (cmd.rdStb && cmd.idx == IDX_STAT) statD = statQ & ~STAT_TXDONE;

    if (cmd.wrStb) begin
      case (cmd.idx)
        IDX_CTRL:   ctrlD   = cmd.wdata | CTRL_FDX;
        IDX_STAT:   statD   = statQ & ~(cmd.wdata & STAT_W1C);
        IDX_TXCTL:  txCtlD  = cmd.wdata;
        IDX_RXCTL:  rxCtlD  = cmd.wdata;
        IDX_PHYCTL: phyCtlD = cmd.wdata;
        IDX_PHYADR: phyAdrD = cmd.wdata;
        IDX_PHYDLO: phyDatD[REG_W-1:0] = cmd.wdata;
        IDX_PHYDHI: phyDatD[2*REG_W-1:REG_W] = cmd.wdata;
        IDX_WAKE:   wakeD   = cmd.wdata;
        IDX_ISR:    isrD    = isrQ & ~cmd.wdata[IRQ_SRC-1:0];
        IDX_IMR:    imrD    = cmd.wdata;
        default:    ;
      endcase
    end

    // frame-sent event: a set request beats a same-cycle clear
    if (txDone) begin
      txCtlD[0] = 1'b0;
      if (pktIdxQ) statD[3] = 1'b1;
      else         statD[2] = 1'b1;
      isrD[ISR_TXBIT] = 1'b1;
      pktIdxD = ~pktIdxQ;
    end

    if (cmd.softRst) begin
      ctrlD   = (cmd.wdata & CTRL_KEEP) | CTRL_FDX;
      statD   = (statQ & STAT_KEEP) | STAT_LINK;
      txCtlD  = '0;
      rxCtlD  = '0;
      imrD    = '0;
      isrD    = '0;
      phyCtlD = '0;
      phyAdrD = PHY_ADDR_RST;
      pktIdxD = 1'b0;
    end
  end

  // hard reset value = soft reset applied to cleared control/status/wake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= CTRL_FDX;
      statQ   <= STAT_LINK;
      txCtlQ  <= '0;
      rxCtlQ  <= '0;
      wakeQ   <= '0;
      imrQ    <= '0;
      isrQ    <= '0;
      phyCtlQ <= '0;
      phyAdrQ <= PHY_ADDR_RST;
      phyDatQ <= '0;
      pktIdxQ <= 1'b0;
    end else begin
      ctrlQ   <= ctrlD;
      statQ   <= statD;
      txCtlQ  <= txCtlD;
      rxCtlQ  <= rxCtlD;
      wakeQ   <= wakeD;
      imrQ    <= imrD;
      isrQ    <= isrD;
      phyCtlQ <= phyCtlD;
      phyAdrQ <= phyAdrD;
      phyDatQ <= phyDatD;
      pktIdxQ <= pktIdxD;
    end
  end

  always_comb begin
    case (cmd.idx)
      IDX_CTRL:   rdData = ctrlQ;
      IDX_STAT:   rdData = statQ;
      IDX_TXCTL:  rdData = txCtlQ;
      IDX_TXST1,
      IDX_TXST2:  rdData = '0;
      IDX_RXCTL:  rdData = rxCtlQ;
      IDX_PHYCTL: rdData = phyCtlQ;
      IDX_PHYADR: rdData = phyAdrQ;
      IDX_PHYDLO: rdData = phyDatQ[REG_W-1:0];
      IDX_PHYDHI: rdData = phyDatQ[2*REG_W-1:REG_W];
      IDX_WAKE:   rdData = wakeQ;
      IDX_VIDL:   rdData = VENDOR_ID[7:0];
      IDX_VIDH:   rdData = VENDOR_ID[15:8];
      IDX_PIDL:   rdData = PRODUCT_ID[7:0];
      IDX_PIDH:   rdData = PRODUCT_ID[15:8];
      IDX_ISR:    rdData = {{(REG_W-IRQ_SRC){1'b0}}, isrQ};
      IDX_IMR:    rdData = imrQ;
      default:    rdData = '0;
    endcase
  end

  assign irqOut = |(isrQ & imrQ[IRQ_SRC-1:0]);
endmodule

// File: rtl/nic_host_regs.sv
module nic_host_regs
  import nic_regs_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID    = 16'h0A46,
  parameter logic [15:0] PRODUCT_ID   = 16'h9000,
  parameter logic [7:0]  PHY_ADDR_RST = 8'h40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic       busIsData,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       txDone,
  output logic       txStart,
  output logic       irqOut
);
  regCmd_t          cmd;
  logic [IDX_W-1:0] curIdx;
  logic [REG_W-1:0] dpRdata;

  nic_regs_ctl u_ctl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busIsData(busIsData), .busWdata(busWdata),
    .cmd(cmd), .curIdx(curIdx), .txStart(txStart)
  );

  nic_regs_dp #(
    .VENDOR_ID(VENDOR_ID), .PRODUCT_ID(PRODUCT_ID), .PHY_ADDR_RST(PHY_ADDR_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .txDone(txDone),
    .rdData(dpRdata), .irqOut(irqOut)
  );

  assign busRdata = busIsData ? dpRdata : curIdx;
endmodule

// File: rtl/nic_host_regs_chk.sv
module nic_host_regs_chk
  import nic_regs_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h0A46
) (
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busWr,
  input logic             busIsData,
  input logic [7:0]       busWdata,
  input logic [7:0]       busRdata,
  input logic             txDone,
  input logic             txStart,
  input logic             irqOut,
  input logic [IDX_W-1:0] curIdx
);
  logic idxWr, idxRd, datWr, datRd;
  assign idxWr = busSel &&  busWr && !busIsData;
  assign idxRd = busSel && !busWr && !busIsData;
  assign datWr = busSel &&  busWr &&  busIsData;
  assign datRd = busSel && !busWr &&  busIsData;

  p_idx_readback_r1: assert property (@(posedge clk) disable iff (!rstN)
    idxWr ##1 idxRd |-> busRdata == $past(busWdata));

  p_isr_clear_all_r3: assert property (@(posedge clk) disable iff (!rstN)
    (datWr && curIdx == IDX_ISR && busWdata[3:0] == 4'hF && !txDone) |=> !irqOut);

  p_stat_rdclr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (datRd && curIdx == IDX_STAT && !txDone) ##1 (datRd && curIdx == IDX_STAT)
      |-> busRdata[3:2] == 2'b00);

  p_ctrl_fdx_r6: assert property (@(posedge clk) disable iff (!rstN)
    (datRd && curIdx == IDX_CTRL) |-> busRdata[3]);

  p_softrst_irq_r7: assert property (@(posedge clk) disable iff (!rstN)
    (datWr && curIdx == IDX_CTRL && busWdata[0]) |=> !irqOut);

  p_txstart_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> $past(datWr && curIdx == IDX_TXCTL && busWdata[0]));

  p_vendor_id_r9: assert property (@(posedge clk) disable iff (!rstN)
    (datRd && curIdx == IDX_VIDL) |-> busRdata == VENDOR_ID[7:0]);
endmodule

bind nic_host_regs nic_host_regs_chk #(.VENDOR_ID(VENDOR_ID)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
  .busIsData(busIsData), .busWdata(busWdata), .busRdata(busRdata),
  .txDone(txDone), .txStart(txStart), .irqOut(irqOut), .curIdx(curIdx)
);

// File: tb/nic_host_regs_tb.sv
module nic_host_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       busSel, busWr, busIsData, txDone;
  logic [7:0] busWdata;
  logic [7:0] busRdata;
  logic       txStart, irqOut;

  int  nChecks = 0;
  int  nFails  = 0;
  logic expPkt = 1'b0;

  nic_host_regs u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busIsData(busIsData), .busWdata(busWdata), .busRdata(busRdata),
    .txDone(txDone), .txStart(txStart), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // one host access; called just after a falling edge
  task automatic access(input logic wr, input logic dport, input logic [7:0] wd,
                        output logic [7:0] rd);
    busSel = 1'b1; busWr = wr; busIsData = dport; busWdata = wd;
    #1 rd = busRdata;
    @(posedge clk); @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic setIdx(input logic [7:0] i);
    logic [7:0] d;
    access(1'b1, 1'b0, i, d);
  endtask

  task automatic wrReg(input logic [7:0] i, input logic [7:0] v);
    logic [7:0] d;
    setIdx(i);
    access(1'b1, 1'b1, v, d);
  endtask

  task automatic rdReg(input logic [7:0] i, output logic [7:0] v);
    setIdx(i);
    access(1'b0, 1'b1, 8'h00, v);
  endtask

  task automatic chkReg(input string req, input logic [7:0] i, input logic [7:0] exp);
    logic [7:0] v;
    rdReg(i, v);
    chk(req, v, exp);
  endtask

  task automatic hardReset();
    rstN = 1'b0; busSel = 0; busWr = 0; busIsData = 0; busWdata = 0; txDone = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expPkt = 1'b0;
  endtask

  // R8: start a frame, check the strobe and pending bit, then complete it
  task automatic sendFrame();
    wrReg(8'h02, 8'h01);
    chk("R8 txStart pulse", {7'b0, txStart}, 8'h01);
    @(negedge clk);
    chk("R8 txStart one cycle", {7'b0, txStart}, 8'h00);
    chkReg("R8 pending bit held", 8'h02, 8'h01);
    txDone = 1'b1;
    @(negedge clk);
    txDone = 1'b0;
    chkReg("R8 pending bit cleared", 8'h02, 8'h00);
    expPkt = ~expPkt;
  endtask

  task automatic testResetState();
    chkReg("R11 ctrl", 8'h00, 8'h08);
    chkReg("R11 status", 8'h01, 8'h40);
    chkReg("R11 phy addr", 8'h0C, 8'h40);
    chkReg("R11 mask", 8'hFF, 8'h00);
    chkReg("R11 int status", 8'hFE, 8'h00);
    chkReg("R11 wake", 8'h0F, 8'h00);
    chk("R11 irq", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic testIndex();
    logic [7:0] v;
    hardReset();
    access(1'b0, 1'b0, 8'h00, v);
    chk("R1 index after reset", v, 8'h00);
    setIdx(8'h2A);
    access(1'b0, 1'b0, 8'h00, v);
    chk("R1 index readback", v, 8'h2A);
    setIdx(8'hC3);
    access(1'b0, 1'b0, 8'h00, v);
    chk("R1 index readback 2", v, 8'hC3);
  endtask

  task automatic testConstants();
    chkReg("R9 vid low", 8'h28, 8'h46);
    chkReg("R9 vid high", 8'h29, 8'h0A);
    chkReg("R9 pid low", 8'h2A, 8'h00);
    chkReg("R9 pid high", 8'h2B, 8'h90);
    chkReg("R9 tx status 1", 8'h03, 8'h00);
    chkReg("R9 tx status 2", 8'h04, 8'h00);
    wrReg(8'h29, 8'h11);
    chkReg("R9 id not writable", 8'h29, 8'h0A);
    wrReg(8'h77, 8'h55);
    chkReg("R10 unknown reads zero", 8'h77, 8'h00);
    chkReg("R10 ctrl untouched", 8'h00, 8'h08);
    chkReg("R10 rx ctrl untouched", 8'h05, 8'h00);
  endtask

  task automatic testPlainRegs();
    wrReg(8'h05, 8'h33); chkReg("R12 rx ctrl", 8'h05, 8'h33);
    wrReg(8'h0B, 8'h0C); chkReg("R12 phy ctrl", 8'h0B, 8'h0C);
    wrReg(8'h0C, 8'h12); chkReg("R12 phy addr", 8'h0C, 8'h12);
    wrReg(8'h0D, 8'h34); wrReg(8'h0E, 8'h56);
    chkReg("R12 phy data low", 8'h0D, 8'h34);
    chkReg("R12 phy data high", 8'h0E, 8'h56);
    wrReg(8'h0F, 8'h5A); chkReg("R12 wake", 8'h0F, 8'h5A);
  endtask

  task automatic testCtrl();
    wrReg(8'h00, 8'h00); chkReg("R6 fdx forced", 8'h00, 8'h08);
    wrReg(8'h00, 8'h42); chkReg("R6 value kept", 8'h00, 8'h4A);
    wrReg(8'h00, 8'h00);
  endtask

  task automatic testTransmit();
    wrReg(8'hFF, 8'h02);
    sendFrame();
    chk("R8 irq after done", {7'b0, irqOut}, 8'h01);
    chkReg("R8 int status bit1", 8'hFE, 8'h02);
    chkReg("R8 status idx0 bit2", 8'h01, 8'h44);
    chkReg("R4 status cleared on read", 8'h01, 8'h40);
    sendFrame();
    chkReg("R8 status idx1 bit3", 8'h01, 8'h48);
    chkReg("R4 bit3 cleared on read", 8'h01, 8'h40);
    sendFrame();
    wrReg(8'h01, 8'hFF);
    chkReg("R5 write-one clears, read-only kept", 8'h01, 8'h40);
    sendFrame();
    wrReg(8'h01, 8'h04);
    chkReg("R5 bit3 kept when written 0", 8'h01, 8'h48);
  endtask

  task automatic testIrq();
    logic [7:0] v;
    chk("R2 irq with mask", {7'b0, irqOut}, 8'h01);
    wrReg(8'hFF, 8'hFD);
    chk("R2 other mask bits no irq", {7'b0, irqOut}, 8'h00);
    wrReg(8'hFF, 8'h02);
    chk("R2 irq re-enabled", {7'b0, irqOut}, 8'h01);
    wrReg(8'hFE, 8'h0D);
    chk("R3 unwritten bit kept", {7'b0, irqOut}, 8'h01);
    rdReg(8'hFE, v);
    chk("R3 status after 0x0D", v, 8'h02);
    wrReg(8'hFE, 8'h02);
    chk("R3 irq dropped", {7'b0, irqOut}, 8'h00);
    chkReg("R3 status cleared", 8'hFE, 8'h00);
  endtask

  task automatic testSoftReset();
    sendFrame();
    wrReg(8'h05, 8'h33);
    wrReg(8'h0C, 8'h12);
    wrReg(8'h0B, 8'h0A);
    wrReg(8'h0F, 8'h5A);
    wrReg(8'h02, 8'h01);
    chk("R7 irq before", {7'b0, irqOut}, 8'h01);
    wrReg(8'h00, 8'hC1);
    expPkt = 1'b0;
    chk("R7 irq cleared", {7'b0, irqOut}, 8'h00);
    chkReg("R7 ctrl kept bits", 8'h00, 8'hC8);
    chkReg("R7 status", 8'h01, 8'h40);
    chkReg("R7 mask", 8'hFF, 8'h00);
    chkReg("R7 int status", 8'hFE, 8'h00);
    chkReg("R7 tx ctrl", 8'h02, 8'h00);
    chkReg("R7 rx ctrl", 8'h05, 8'h00);
    chkReg("R7 phy ctrl", 8'h0B, 8'h00);
    chkReg("R7 phy addr", 8'h0C, 8'h40);
    chkReg("R7 wake untouched", 8'h0F, 8'h5A);
    sendFrame();
    chkReg("R7 packet index reset", 8'h01, 8'h44);
  endtask

  task automatic testHardReset();
    hardReset();
    chkReg("R11 ctrl bits 7..6 cleared", 8'h00, 8'h08);
    chkReg("R11 wake cleared", 8'h0F, 8'h00);
    chkReg("R11 phy data", 8'h0D, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL watchdog: got 0x00 expected 0x01");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    hardReset();
    testResetState();
    testIndex();
    testConstants();
    testPlainRegs();
    testCtrl();
    testTransmit();
    testIrq();
    testSoftReset();
    testHardReset();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule